// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block gives a host an indirect window onto a small configuration space over an 8-bit I/O bus. Two bus addresses are decoded. One selects a register (the index port) and the other reads or writes the selected register (the data port). After reset the window is closed. It opens only after a four-byte key has been written to the index port. While closed, every read returns all ones, so a host probing for the device sees the same pattern it would see from an empty slot.

Once open, the host selects a logical device through a device-number register. Indices in the device range then address that device's own copy of a bank of registers. A read-only chip identifier and revision sit at fixed indices. The registers of one chosen logical device, a watchdog by default, are driven out in parallel so that the attached function can use them. Writing the exit code to the exit index closes the window again.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_mode` low), `bus_rdata` is 0xFF, the index and device-number registers are 0x00 and every bank register is 0x00.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to the index port (address 0x2E) in that order unlocks the port. `cfg_mode` goes high on the clock edge that takes the fourth byte.
- R3: A byte written to the index port while locked that is not the expected next key byte restarts the key match. If that byte is 0x87 it counts as the first key byte, otherwise the match begins again from nothing.
- R4: While locked, writes to the data port (0x2F) are ignored, writes to the index port only feed the key match and do not change the index register, and reads of either port return 0xFF.
- R5: While unlocked, a write to the index port sets the index register and a read of the index port returns it. Any read returns its data on `bus_rdata` one clock after the read strobe, and `bus_rdata` holds between reads.
- R6: Index 0x07 is the logical-device number register, an 8-bit read/write register.
- R7: Indices 0x20 and 0x21 read the high and low bytes of the 16-bit chip ID parameter. Writes to them are ignored.
- R8: Index 0x22 reads as 0x0 in bits 7:4 and the 4-bit revision parameter in bits 3:0. Writes to it are ignored.
- R9: Indices 0x70 to 0x7F address a 16-register bank, and each logical device 0 to 7 has its own copy. When the device number is 8 or higher, bank writes are ignored and bank reads return 0xFF.
- R10: `tap_regs[8*k+7:8*k]` always equals bank register 0x70+k of logical device 7.
- R11: Writing 0x02 to the data port while the index is 0x02 locks the port. Other values written there leave it unlocked. After locking, the full key is needed again.
- R12: While unlocked, reads of indices that hold no register (for example 0x02 or 0x30) return 0xFF. Bus accesses to any address other than 0x2E and 0x2F have no effect, and reads at such addresses return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| cfg_mode | output | 1 | High while the configuration window is unlocked |
| tap_regs | output | 128 | Bank registers of the tapped logical device, register 0x70 in bits 7:0 |

## Verification
A key matcher stuck in the wrong stage shows up on `cfg_mode`. It goes high one key byte early or late, or it never goes high after a mismatch followed by a fresh key. A wrong device number or bank address shows up on the next data read as another device's value, and at once on `tap_regs` after a write. A lock flag that fails to clear on exit shows up on the very next read, which returns a register value instead of 0xFF.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int KEY_LEN = 4;

  localparam logic [7:0] IDX_EXIT = 8'h02;
  localparam logic [7:0] IDX_LDN  = 8'h07;
  localparam logic [7:0] IDX_IDHI = 8'h20;
  localparam logic [7:0] IDX_IDLO = 8'h21;
  localparam logic [7:0] IDX_REV  = 8'h22;
  localparam logic [7:0] EXIT_CODE = 8'h02;
  localparam logic [7:0] ALL_ONES  = 8'hFF;

  function automatic logic [7:0] key_byte(input logic [1:0] stage);
    case (stage)
      2'd0:    return 8'h87;
      2'd1:    return 8'h01;
      default: return 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       lock_req,
  output logic       unlocked
);
  localparam int ST_W = $clog2(KEY_LEN);

  logic [ST_W-1:0] stage_q;
  logic            unl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      unl_q   <= 1'b0;
    end else if (lock_req) begin
      stage_q <= '0;
      unl_q   <= 1'b0;
    end else if (key_wr && !unl_q) begin
      if (key_data == key_byte(stage_q)) begin
        if (stage_q == ST_W'(KEY_LEN - 1)) begin
          stage_q <= '0;
          unl_q   <= 1'b1;
        end else begin
          stage_q <= stage_q + 1'b1;
        end
      end else begin
        stage_q <= (key_data == key_byte(2'd0)) ? ST_W'(1) : '0;
      end
    end
  end

  assign unlocked = unl_q;

  // R2: opening happens only on a final key byte
  p_open_on_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_wr && key_data == 8'h55));

  // R11: a lock request always closes the window
  p_lock_closes_r11: assert property (@(posedge clk) disable iff (rst)
    lock_req |=> !unlocked);
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank #(
  parameter int NUM_LDN   = 8,
  parameter int BANK_REGS = 16,
  parameter int TAP_LDN   = 7,
  localparam int LDN_W    = $clog2(NUM_LDN),
  localparam int OFF_W    = $clog2(BANK_REGS),
  localparam int DEPTH    = NUM_LDN * BANK_REGS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [LDN_W-1:0]       ldn,
  input  logic [OFF_W-1:0]       off,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [BANK_REGS*8-1:0] tap_regs
);
  localparam int ADR_W = LDN_W + OFF_W;

  logic [7:0]       mem [DEPTH];
  logic [ADR_W-1:0] adr;

  assign adr = {ldn, off};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[adr] <= wdata;
    end
  end

  assign rdata = mem[adr];

  for (genvar k = 0; k < BANK_REGS; k++) begin : g_tap
    assign tap_regs[8*k +: 8] = mem[TAP_LDN*BANK_REGS + k];
  end

  // R10: the tapped registers move only on a bank write
  p_tap_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(tap_regs));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h002E,
  parameter logic [15:0] DAT_PORT  = 16'h002F,
  parameter logic [15:0] CHIP_ID   = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV  = 4'h6,
  parameter int          NUM_LDN   = 8,
  parameter int          BANK_BASE = 8'h70,
  parameter int          BANK_REGS = 16,
  parameter int          TAP_LDN   = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  output logic [7:0]             bus_rdata,
  output logic                   cfg_mode,
  output logic [BANK_REGS*8-1:0] tap_regs
);
  localparam int LDN_W = $clog2(NUM_LDN);
  localparam int OFF_W = $clog2(BANK_REGS);

  logic       unlocked;
  logic [7:0] idx_q, ldn_q, rdata_q, rd_next, bank_rd;
  logic       hit_idx, hit_dat, in_bank, ldn_ok, lock_req, bank_we;
  logic [7:0] off_full;

  assign hit_idx = (bus_addr == ADDR_W'(IDX_PORT));
  assign hit_dat = (bus_addr == ADDR_W'(DAT_PORT));
  assign in_bank = ({1'b0, idx_q} >= 9'(BANK_BASE)) &&
                   ({1'b0, idx_q} <  9'(BANK_BASE + BANK_REGS));
  assign ldn_ok  = ({1'b0, ldn_q} < 9'(NUM_LDN));
  assign off_full = idx_q - 8'(BANK_BASE);
  assign lock_req = unlocked && bus_wr && hit_dat &&
                    idx_q == IDX_EXIT && bus_wdata == EXIT_CODE;
  assign bank_we  = unlocked && bus_wr && hit_dat && in_bank && ldn_ok;

  sio_key_match u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (bus_wr && hit_idx),
    .key_data (bus_wdata),
    .lock_req (lock_req),
    .unlocked (unlocked)
  );

  sio_dev_bank #(
    .NUM_LDN   (NUM_LDN),
    .BANK_REGS (BANK_REGS),
    .TAP_LDN   (TAP_LDN)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (bank_we),
    .ldn      (ldn_q[LDN_W-1:0]),
    .off      (off_full[OFF_W-1:0]),
    .wdata    (bus_wdata),
    .rdata    (bank_rd),
    .tap_regs (tap_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else if (unlocked && bus_wr) begin
      if (hit_idx) idx_q <= bus_wdata;
      else if (hit_dat && idx_q == IDX_LDN) ldn_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = ALL_ONES;
    if (unlocked) begin
      if (hit_idx) begin
        rd_next = idx_q;
      end else if (hit_dat) begin
        if (idx_q == IDX_LDN)       rd_next = ldn_q;
        else if (idx_q == IDX_IDHI) rd_next = CHIP_ID[15:8];
        else if (idx_q == IDX_IDLO) rd_next = CHIP_ID[7:0];
        else if (idx_q == IDX_REV)  rd_next = {4'h0, CHIP_REV};
        else if (in_bank && ldn_ok) rd_next = bank_rd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= ALL_ONES;
    else if (bus_rd) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign cfg_mode  = unlocked;

  // R4: a locked read always returns all ones
  p_locked_read_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !cfg_mode) |=> bus_rdata == ALL_ONES);

  // R4: the device number cannot change while locked
  p_ldn_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(ldn_q));

  // R5: read data holds between reads
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R12: foreign addresses never return data
  p_foreign_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit_idx && !hit_dat) |=> bus_rdata == ALL_ONES);
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_rdata;
  logic         cfg_mode;
  logic [127:0] tap_regs;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  sio_cfg_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cfg_mode(cfg_mode), .tap_regs(tap_regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic io_rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    io_wr(IP, idx);
    io_wr(DP, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, output logic [7:0] d);
    io_wr(IP, idx);
    io_rd(DP, d);
  endtask

  task automatic send_key();
    io_wr(IP, 8'h87); io_wr(IP, 8'h01); io_wr(IP, 8'h55); io_wr(IP, 8'h55);
  endtask

  task automatic leave();
    reg_wr(8'h02, 8'h02);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cfg_mode", cfg_mode, 0);
    chk("R1 rdata", bus_rdata, 8'hFF);
    chk("R1 tap", tap_regs, 0);
    io_rd(DP, d);
    chk("R1 R4 locked data read", d, 8'hFF);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    io_wr(IP, 8'h07);
    io_wr(DP, 8'h05);
    io_rd(IP, d);
    chk("R4 locked index read", d, 8'hFF);
    send_key();
    io_rd(IP, d);
    chk("R4 index unchanged while locked", d, 8'h00);
    reg_rd(8'h07, d);
    chk("R4 ldn unchanged while locked", d, 8'h00);
    leave();
  endtask

  task automatic t_key();
    logic [7:0] d;
    io_wr(IP, 8'h87); io_wr(IP, 8'h01); io_wr(IP, 8'h55);
    chk("R2 three bytes stay locked", cfg_mode, 0);
    io_wr(IP, 8'h55);
    chk("R2 fourth byte unlocks", cfg_mode, 1);
    reg_rd(8'h20, d);
    chk("R2 R7 id readable", d, 8'hA5);
    leave();
    chk("R11 exit locks", cfg_mode, 0);
    io_wr(IP, 8'h87); io_wr(IP, 8'h01); io_wr(IP, 8'h33);
    io_wr(IP, 8'h55); io_wr(IP, 8'h55);
    chk("R3 wrong byte restarts", cfg_mode, 0);
    io_wr(IP, 8'h87); io_wr(IP, 8'h87); io_wr(IP, 8'h01);
    io_wr(IP, 8'h55); io_wr(IP, 8'h55);
    chk("R3 repeated first byte counts", cfg_mode, 1);
    leave();
    io_wr(IP, 8'h01); io_wr(IP, 8'h55); io_wr(IP, 8'h55);
    chk("R3 key from middle stays locked", cfg_mode, 0);
  endtask

  task automatic t_id();
    logic [7:0] d;
    send_key();
    io_wr(IP, 8'h21);
    io_rd(IP, d);
    chk("R5 index readback", d, 8'h21);
    io_rd(DP, d);
    chk("R7 id low", d, 8'hC3);
    reg_wr(8'h20, 8'h00);
    reg_rd(8'h20, d);
    chk("R7 id high read only", d, 8'hA5);
    reg_rd(8'h22, d);
    chk("R8 revision", d, 8'h06);
    reg_wr(8'h22, 8'hFF);
    reg_rd(8'h22, d);
    chk("R8 revision read only", d, 8'h06);
    io_wr(IP, 8'h22);
    io_rd(DP, d);
    @(negedge clk);
    chk("R5 rdata holds", bus_rdata, 8'h06);
  endtask

  task automatic t_bank();
    logic [7:0] d;
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h07, d);
    chk("R6 ldn readback", d, 8'h07);
    reg_wr(8'h70, 8'h11);
    reg_wr(8'h7F, 8'h22);
    chk("R10 tap low", tap_regs[7:0], 8'h11);
    chk("R10 tap high", tap_regs[127:120], 8'h22);
    reg_wr(8'h07, 8'h03);
    reg_wr(8'h70, 8'h33);
    reg_rd(8'h70, d);
    chk("R9 ldn3 bank", d, 8'h33);
    chk("R10 tap unaffected by ldn3", tap_regs[7:0], 8'h11);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h70, d);
    chk("R9 ldn7 own copy", d, 8'h11);
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h70, 8'h44);
    reg_rd(8'h70, d);
    chk("R9 absent ldn reads ones", d, 8'hFF);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h70, d);
    chk("R9 absent ldn write ignored", d, 8'h33);
    reg_wr(8'h07, 8'h07);
  endtask

  task automatic t_other();
    logic [7:0] d;
    reg_rd(8'h30, d);
    chk("R12 unused index", d, 8'hFF);
    reg_rd(8'h02, d);
    chk("R12 exit index reads ones", d, 8'hFF);
    io_rd(16'h0080, d);
    chk("R12 foreign read", d, 8'hFF);
    io_wr(IP, 8'h70);
    io_wr(16'h012F, 8'h99);
    io_rd(DP, d);
    chk("R12 foreign write ignored", d, 8'h11);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    reg_wr(8'h02, 8'h01);
    chk("R11 other value keeps open", cfg_mode, 1);
    reg_wr(8'h02, 8'h02);
    chk("R11 exit code locks", cfg_mode, 0);
    io_rd(DP, d);
    chk("R11 R4 read after exit", d, 8'hFF);
    io_wr(DP, 8'h55);
    chk("R11 tap kept after exit", tap_regs[7:0], 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_locked();
    t_key();
    t_id();
    t_bank();
    t_other();
    t_exit();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule